// File: doc/BRIEF.md
# Ultra-Low-Power State Entry/Exit Sequencer

This block sits on the protocol side of one serial lane. It runs the handshake that puts the lane into its ultra-low-power state (ULPS) and brings it back out. All of its traffic with the PHY is on the escape-clock domain. A sleep command is taken only while the PHY reports the lane in stop state. The sequencer then raises the escape request with the ULPS selection and holds it until the PHY's active-low ULP flag goes low. Only then does it report the lane as asleep.

A wake command raises the exit signal. The sequencer waits for the ULP flag to return high, which means Mark-1 is on the line. It then holds the request for a wakeup interval. The interval is a programmable number of escape-clock cycles, and it never drops below the cycle count of one millisecond at the configured clock rate. After the interval the request and the exit signal drop together, and the sequencer waits for stop state before reporting completion. A watchdog covers every phase that waits on the PHY. If the PHY does not respond within a programmable cycle limit, the watchdog raises an error and the sequencer returns to idle.

A build parameter selects clock-lane operation. In that mode a dedicated clock-lane ULPS request replaces the escape request and its selection fields.

Top module: `ulps_seq`

## Requirements
- R1: While reset is held and in the first cycle after reset, all request, select, exit, status, done and error outputs are 0.
- R2: A sleep command is accepted only when the sequencer is idle and stop_state is 1. The request output rises in the cycle after the command is sampled. A sleep command sampled while stop_state is 0, or while the lane is already asleep, has no effect.
- R3: In data-lane mode, whenever esc_req is 1 the following hold: esc_ulps_sel is 1, esc_req_type is 4'b0001 (the ULPS code), esc_lpdt_sel is 0, esc_trig_sel is 4'b0000 and clk_ulps_req is 0.
- R4: asleep rises only in the cycle after ulp_active_n is sampled 0 while the entry request is pending. Before that, asleep stays 0.
- R5: A wake command raises ulps_exit in the next cycle, but only when asleep is 1. A wake command sampled in any other phase leaves ulps_exit at 0.
- R6: Once ulp_active_n is sampled 1 during exit, the request stays high for exactly max(wake_cycles, WAKE_MIN) more cycles. WAKE_MIN equals ESC_CLK_KHZ, which is one millisecond of escape clock.
- R7: The request and ulps_exit fall in the same cycle. done is a one-cycle pulse in the cycle after stop_state is then sampled 1, and busy returns to 0 with it.
- R8: If the sequencer waits for the flag to fall, the flag to rise, or stop state, and more than timeout_limit cycles pass without the expected change, err pulses for one cycle. In that same cycle the request and ulps_exit are 0 and the sequencer is idle. If the expected change is sampled in the cycle the limit expires, the change wins.
- R9: In clock-lane mode, clk_ulps_req carries the request. esc_req and esc_ulps_sel stay 0, and esc_req_type stays 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Escape-mode clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_cmd | input | 1 | Command to enter ULPS |
| wake_cmd | input | 1 | Command to leave ULPS |
| wake_cycles | input | CNT_W | Requested wakeup hold, in clock cycles |
| timeout_limit | input | CNT_W | Watchdog limit per waiting phase, in cycles |
| stop_state | input | 1 | PHY reports lane in stop state |
| ulp_active_n | input | 1 | PHY ULP flag, low while lane is in ULPS |
| esc_req | output | 1 | Escape request (data-lane mode) |
| esc_ulps_sel | output | 1 | ULPS selection with the escape request |
| esc_lpdt_sel | output | 1 | Low-power data selection, held 0 |
| esc_trig_sel | output | 4 | Trigger selections, held 0 |
| esc_req_type | output | 4 | Coded request type, 4'b0001 for ULPS |
| clk_ulps_req | output | 1 | Clock-lane ULPS request (clock-lane mode) |
| ulps_exit | output | 1 | Exit sequence request to the PHY |
| asleep | output | 1 | Lane confirmed in ULPS |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle pulse: exit completed |
| err | output | 1 | One-cycle pulse: watchdog expired |

## Verification
Two functions can meet in one cycle: the watchdog reaching its limit and the PHY flag making its expected change. The bench counts cycles from the rise of the request and flips ulp_active_n so that the FSM samples it on the same edge on which the limit expires. The design is correct if asleep follows and err stays low. A second run moves the flip one cycle later and expects the error pulse. Wake commands are also sent while the entry request is still pending, which is the cycle the flag may fall. They must leave ulps_exit low.

// File: rtl/ulps_pkg.sv
// Package: shared state type and codes for the ULPS sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ulps_pkg;

    // Sequencer phases; the waiting phases are ENTER, EXIT and RELEASE.
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_ENTER   = 3'd1,
        S_ASLEEP  = 3'd2,
        S_EXIT    = 3'd3,
        S_WAKE    = 3'd4,
        S_RELEASE = 3'd5
    } ulps_state_t;

    // Coded request type for ULPS when the 4-bit type field is used.
    localparam logic [3:0] REQ_TYPE_ULPS = 4'b0001;
    localparam logic [3:0] REQ_TYPE_NONE = 4'b0000;

endpackage

// File: rtl/ulps_wake_timer.sv
// Module: wakeup hold counter.
// Loads max(cycles, MIN_CYC) on 'load' and counts down while 'run' is high.
// 'expire' is high in the last cycle of the hold.
// Assumes: MIN_CYC >= 1 and MIN_CYC fits in CNT_W bits.
module ulps_wake_timer #(
    parameter int CNT_W   = 24,
    parameter int MIN_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] cycles,
    output logic             expire
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] eff;

    // Purpose: apply the one-millisecond floor to the requested hold.
    always_comb begin
        eff = (cycles < MIN_V) ? MIN_V : cycles;
    end

    // Purpose: hold the remaining cycles of the wakeup interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= eff;
        end else if (run && (cnt > CNT_W'(1))) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Purpose: flag the final cycle of the interval.
    always_comb begin
        expire = run && (cnt <= CNT_W'(1));
    end

endmodule

// File: rtl/ulps_watchdog.sv
// Module: per-phase response watchdog.
// Counts the cycles spent in a waiting phase and clears whenever the phase is
// left. 'expired' is high once the count reaches 'limit'.
// Assumes: each waiting phase is entered from a non-waiting phase, so the
// count always starts at zero.
module ulps_watchdog #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;

    // Purpose: count waiting cycles, saturating, and clear when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Purpose: compare the elapsed wait against the programmed limit.
    always_comb begin
        expired = armed && (cnt >= limit);
    end

endmodule

// File: rtl/ulps_fsm.sv
// Module: ULPS handshake state machine.
// Walks idle -> enter -> asleep -> exit -> wake hold -> release -> idle.
// Issues one-cycle done or err pulses when it returns to idle.
// Assumes: inputs are synchronous to clk; a PHY response sampled in the
// same cycle as watchdog expiry takes priority over the expiry.
module ulps_fsm
    import ulps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_cmd,
    input  logic        wake_cmd,
    input  logic        stop_state,
    input  logic        ulp_active_n,
    input  logic        wake_expire,
    input  logic        wd_expire,
    output ulps_state_t st,
    output logic        wake_load,
    output logic        wake_run,
    output logic        wd_armed,
    output logic        done,
    output logic        err
);
    ulps_state_t nxt;
    logic        fin_ok;
    logic        fin_err;

    // Purpose: choose the next phase from commands and PHY responses.
    always_comb begin
        nxt     = st;
        fin_ok  = 1'b0;
        fin_err = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (sleep_cmd && stop_state) nxt = S_ENTER;
            end
            S_ENTER: begin
                if (!ulp_active_n) begin
                    nxt = S_ASLEEP;
                end else if (wd_expire) begin
                    nxt     = S_IDLE;
                    fin_err = 1'b1;
                end
            end
            S_ASLEEP: begin
                if (wake_cmd) nxt = S_EXIT;
            end
            S_EXIT: begin
                if (ulp_active_n) begin
                    nxt = S_WAKE;
                end else if (wd_expire) begin
                    nxt     = S_IDLE;
                    fin_err = 1'b1;
                end
            end
            S_WAKE: begin
                if (wake_expire) nxt = S_RELEASE;
            end
            S_RELEASE: begin
                if (stop_state) begin
                    nxt    = S_IDLE;
                    fin_ok = 1'b1;
                end else if (wd_expire) begin
                    nxt     = S_IDLE;
                    fin_err = 1'b1;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // Purpose: hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // Purpose: register the completion and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= fin_ok;
            err  <= fin_err;
        end
    end

    // Purpose: derive timer controls from the phase.
    always_comb begin
        wake_load = (st == S_EXIT) && (nxt == S_WAKE);
        wake_run  = (st == S_WAKE);
        wd_armed  = (st == S_ENTER) || (st == S_EXIT) || (st == S_RELEASE);
    end

endmodule

// File: rtl/ulps_lane_drive.sv
// Module: maps the sequencer phase onto the lane's PPI-side outputs.
// CLOCK_LANE selects the dedicated clock-lane request instead of the escape
// request and its selection fields.
// Assumes: the phase input is a registered state, so outputs are glitch-free.
module ulps_lane_drive
    import ulps_pkg::*;
#(
    parameter bit CLOCK_LANE = 1'b0
) (
    input  ulps_state_t st,
    output logic        esc_req,
    output logic        esc_ulps_sel,
    output logic        esc_lpdt_sel,
    output logic [3:0]  esc_trig_sel,
    output logic [3:0]  esc_req_type,
    output logic        clk_ulps_req,
    output logic        ulps_exit,
    output logic        asleep,
    output logic        busy
);
    logic req_phase;

    // Purpose: decode the phases that hold the request and the exit signal.
    always_comb begin
        req_phase = (st == S_ENTER) || (st == S_ASLEEP) ||
                    (st == S_EXIT)  || (st == S_WAKE);
        ulps_exit = (st == S_EXIT) || (st == S_WAKE);
        asleep    = (st == S_ASLEEP);
        busy      = (st != S_IDLE);
    end

    // Other escape selects never accompany a ULPS request.
    assign esc_lpdt_sel = 1'b0;
    assign esc_trig_sel = 4'b0000;

    generate
        if (CLOCK_LANE) begin : g_clk_lane
            assign clk_ulps_req = req_phase;
            assign esc_req      = 1'b0;
            assign esc_ulps_sel = 1'b0;
            assign esc_req_type = REQ_TYPE_NONE;
        end else begin : g_data_lane
            assign clk_ulps_req = 1'b0;
            assign esc_req      = req_phase;
            assign esc_ulps_sel = req_phase;
            assign esc_req_type = req_phase ? REQ_TYPE_ULPS : REQ_TYPE_NONE;
        end
    endgenerate

endmodule

// File: rtl/ulps_seq.sv
// Module: top of the ULPS entry/exit sequencer for one lane.
// Combines the handshake FSM, the wakeup hold timer, the response watchdog
// and the lane output decode.
// Assumes: clk is the escape clock at ESC_CLK_KHZ kHz; ESC_CLK_KHZ < 2**CNT_W.
module ulps_seq
    import ulps_pkg::*;
#(
    parameter bit CLOCK_LANE  = 1'b0,
    parameter int CNT_W       = 24,
    parameter int ESC_CLK_KHZ = 20000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_cmd,
    input  logic             wake_cmd,
    input  logic [CNT_W-1:0] wake_cycles,
    input  logic [CNT_W-1:0] timeout_limit,
    input  logic             stop_state,
    input  logic             ulp_active_n,
    output logic             esc_req,
    output logic             esc_ulps_sel,
    output logic             esc_lpdt_sel,
    output logic [3:0]       esc_trig_sel,
    output logic [3:0]       esc_req_type,
    output logic             clk_ulps_req,
    output logic             ulps_exit,
    output logic             asleep,
    output logic             busy,
    output logic             done,
    output logic             err
);
    // One millisecond of escape clock.
    localparam int WAKE_MIN = ESC_CLK_KHZ;

    ulps_state_t st;
    logic        wake_load;
    logic        wake_run;
    logic        wake_expire;
    logic        wd_armed;
    logic        wd_expire;

    ulps_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_cmd    (sleep_cmd),
        .wake_cmd     (wake_cmd),
        .stop_state   (stop_state),
        .ulp_active_n (ulp_active_n),
        .wake_expire  (wake_expire),
        .wd_expire    (wd_expire),
        .st           (st),
        .wake_load    (wake_load),
        .wake_run     (wake_run),
        .wd_armed     (wd_armed),
        .done         (done),
        .err          (err)
    );

    ulps_wake_timer #(
        .CNT_W   (CNT_W),
        .MIN_CYC (WAKE_MIN)
    ) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wake_load),
        .run    (wake_run),
        .cycles (wake_cycles),
        .expire (wake_expire)
    );

    ulps_watchdog #(
        .CNT_W (CNT_W)
    ) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (wd_armed),
        .limit   (timeout_limit),
        .expired (wd_expire)
    );

    ulps_lane_drive #(
        .CLOCK_LANE (CLOCK_LANE)
    ) u_drive (
        .st           (st),
        .esc_req      (esc_req),
        .esc_ulps_sel (esc_ulps_sel),
        .esc_lpdt_sel (esc_lpdt_sel),
        .esc_trig_sel (esc_trig_sel),
        .esc_req_type (esc_req_type),
        .clk_ulps_req (clk_ulps_req),
        .ulps_exit    (ulps_exit),
        .asleep       (asleep),
        .busy         (busy)
    );

endmodule

// File: rtl/ulps_seq_chk.sv
// Module: protocol checker for ulps_seq, attached by bind below.
// Observes only the top-level ports.
// Assumes: the PHY keeps ulp_active_n high for the whole wakeup hold.
module ulps_seq_chk #(
    parameter int WAKE_MIN = 1
) (
    input logic clk,
    input logic rst_n,
    input logic sleep_cmd,
    input logic wake_cmd,
    input logic stop_state,
    input logic ulp_active_n,
    input logic esc_req,
    input logic clk_ulps_req,
    input logic ulps_exit,
    input logic asleep,
    input logic busy,
    input logic done,
    input logic err
);
    logic        any_req;
    logic [31:0] hold_cnt;

    assign any_req = esc_req || clk_ulps_req;

    // Purpose: count sampled cycles with exit high and the ULP flag released.
    always_ff @(posedge clk) begin
        if (!rst_n || !ulps_exit || !ulp_active_n) begin
            hold_cnt <= '0;
        end else if (hold_cnt != 32'hFFFF_FFFF) begin
            hold_cnt <= hold_cnt + 32'd1;
        end
    end

    a_r2_req_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_req) |-> ($past(stop_state) && $past(sleep_cmd)));

    a_r4_asleep_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(!ulp_active_n));

    a_r5_exit_from_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ulps_exit) |-> ($past(asleep) && $past(wake_cmd)));

    a_r7_exit_within_req: assert property (@(posedge clk) disable iff (!rst_n)
        ulps_exit |-> any_req);

    a_r7_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(stop_state) && !any_req && !busy));

    a_r8_err_drops_all: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!any_req && !ulps_exit && !busy && !done));

    a_r6_wake_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ulps_exit) && !err) |-> (hold_cnt > 32'(WAKE_MIN)));

endmodule

bind ulps_seq ulps_seq_chk #(
    .WAKE_MIN (WAKE_MIN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_cmd    (sleep_cmd),
    .wake_cmd     (wake_cmd),
    .stop_state   (stop_state),
    .ulp_active_n (ulp_active_n),
    .esc_req      (esc_req),
    .clk_ulps_req (clk_ulps_req),
    .ulps_exit    (ulps_exit),
    .asleep       (asleep),
    .busy         (busy),
    .done         (done),
    .err          (err)
);

// File: tb/sim_ulps_seq.sv
module sim_ulps_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 16;
    localparam int KHZ        = 6;
    localparam int MIN        = KHZ;
    localparam int BIG_LIMIT  = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] wake_cycles = '0;
    logic [CW-1:0] timeout_limit = CW'(BIG_LIMIT);

    // data-lane instance signals
    logic sleep_cmd = 1'b0, wake_cmd = 1'b0, stop_state = 1'b1, flag_n = 1'b1;
    logic esc_req, esc_ulps_sel, esc_lpdt_sel, clk_ulps_req, ulps_exit;
    logic asleep, busy, done, err;
    logic [3:0] esc_trig_sel, esc_req_type;

    // clock-lane instance signals
    logic c_sleep = 1'b0, c_wake = 1'b0, c_stop = 1'b1, c_flag = 1'b1;
    logic c_esc_req, c_sel, c_lpdt, c_clk_req, c_exit, c_asleep, c_busy, c_done, c_err;
    logic [3:0] c_trig, c_type;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ulps_seq #(.CLOCK_LANE(1'b0), .CNT_W(CW), .ESC_CLK_KHZ(KHZ)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .wake_cmd(wake_cmd),
        .wake_cycles(wake_cycles), .timeout_limit(timeout_limit),
        .stop_state(stop_state), .ulp_active_n(flag_n),
        .esc_req(esc_req), .esc_ulps_sel(esc_ulps_sel), .esc_lpdt_sel(esc_lpdt_sel),
        .esc_trig_sel(esc_trig_sel), .esc_req_type(esc_req_type),
        .clk_ulps_req(clk_ulps_req), .ulps_exit(ulps_exit), .asleep(asleep),
        .busy(busy), .done(done), .err(err)
    );

    ulps_seq #(.CLOCK_LANE(1'b1), .CNT_W(CW), .ESC_CLK_KHZ(KHZ)) u1 (
        .clk(clk), .rst_n(rst_n), .sleep_cmd(c_sleep), .wake_cmd(c_wake),
        .wake_cycles(wake_cycles), .timeout_limit(timeout_limit),
        .stop_state(c_stop), .ulp_active_n(c_flag),
        .esc_req(c_esc_req), .esc_ulps_sel(c_sel), .esc_lpdt_sel(c_lpdt),
        .esc_trig_sel(c_trig), .esc_req_type(c_type),
        .clk_ulps_req(c_clk_req), .ulps_exit(c_exit), .asleep(c_asleep),
        .busy(c_busy), .done(c_done), .err(c_err)
    );

    function automatic int exp_hold(input int w);
        return (w < MIN) ? MIN : w;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Sleep entry on u0; PHY drops the flag after enter_dly cycles.
    // stray_wake sends wake commands while entry is pending (must be ignored).
    task automatic do_sleep(input int enter_dly, input bit stray_wake);
        stop_state = 1'b1; flag_n = 1'b1; sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        chk("R2 req rises after sleep", int'(esc_req), 1);
        chk("R3 ulps select", int'(esc_ulps_sel), 1);
        chk("R3 request type", int'(esc_req_type), 1);
        chk("R3 other selects", int'({esc_lpdt_sel, esc_trig_sel, clk_ulps_req}), 0);
        stop_state = 1'b0;
        for (int i = 0; i < enter_dly; i++) begin
            wake_cmd = stray_wake;
            @(negedge clk);
            chk("R4 not asleep before flag", int'(asleep), 0);
            chk("R5 wake ignored during entry", int'(ulps_exit), 0);
        end
        wake_cmd = 1'b0;
        flag_n = 1'b0;
        @(negedge clk);
        chk("R4 asleep after flag low", int'(asleep), 1);
        chk("R5 no exit yet", int'(ulps_exit), 0);
    endtask

    // Wake from asleep on u0 with hold w; PHY raises flag after exit_dly.
    task automatic do_wake(input int exit_dly, input int w);
        int n;
        wake_cycles = CW'(w);
        wake_cmd = 1'b1;
        @(negedge clk);
        wake_cmd = 1'b0;
        chk("R5 exit raised", int'(ulps_exit), 1);
        chk("R5 asleep cleared", int'(asleep), 0);
        for (int i = 0; i < exit_dly; i++) begin
            @(negedge clk);
            chk("R6 req held while flag low", int'(esc_req & ulps_exit), 1);
        end
        flag_n = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            if (!esc_req || n > 5000) break;
            n++;
        end
        chk("R6 wake hold length", n, exp_hold(w));
        chk("R7 exit falls with req", int'(ulps_exit), 0);
        chk("R7 no done before stop", int'(done), 0);
        stop_state = 1'b1;
        @(negedge clk);
        chk("R7 done pulse", int'(done), 1);
        chk("R7 idle at done", int'(busy | esc_req), 0);
        @(negedge clk);
        chk("R7 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));

        // R1: outputs quiet under reset and right after
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'({esc_req, esc_ulps_sel, esc_req_type, clk_ulps_req,
                                      ulps_exit, asleep, busy, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", int'({esc_req, ulps_exit, asleep, busy, done, err}), 0);
        chk("R1 clock lane after reset", int'({c_clk_req, c_exit, c_busy}), 0);

        // R2: sleep ignored without stop state
        stop_state = 1'b0; sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        chk("R2 sleep ignored without stop", int'(esc_req | busy), 0);
        @(negedge clk);
        chk("R2 still idle", int'(busy), 0);

        // R5: wake ignored while idle
        stop_state = 1'b1; wake_cmd = 1'b1;
        @(negedge clk);
        wake_cmd = 1'b0;
        chk("R5 wake ignored in idle", int'(ulps_exit | busy), 0);

        // Directed full cycle with wake below the floor, and sleep while asleep
        do_sleep(2, 1'b1);
        sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        chk("R2 sleep while asleep ignored", int'(asleep & ~ulps_exit), 1);
        do_wake(1, 0);

        // Wake at the floor and above it
        do_sleep(0, 1'b0);
        do_wake(0, MIN);
        do_sleep(1, 1'b0);
        do_wake(3, MIN + 9);

        // R8: flag change in the expiry cycle wins
        timeout_limit = CW'(5);
        stop_state = 1'b1; flag_n = 1'b1; sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0; stop_state = 1'b0;
        repeat (5) @(negedge clk);
        flag_n = 1'b0;
        @(negedge clk);
        chk("R8 flag wins at expiry: asleep", int'(asleep), 1);
        chk("R8 flag wins at expiry: no err", int'(err), 0);
        timeout_limit = CW'(BIG_LIMIT);
        do_wake(0, 2);

        // R8: entry timeout one cycle later
        timeout_limit = CW'(5);
        stop_state = 1'b1; flag_n = 1'b1; sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0; stop_state = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk("R8 no early err", int'(err), 0);
        end
        @(negedge clk);
        chk("R8 entry timeout err", int'(err), 1);
        chk("R8 req dropped on err", int'(esc_req | ulps_exit | busy), 0);
        @(negedge clk);
        chk("R8 err one cycle", int'(err), 0);

        // R8: exit timeout (flag never rises)
        timeout_limit = CW'(BIG_LIMIT);
        do_sleep(0, 1'b0);
        timeout_limit = CW'(4);
        wake_cmd = 1'b1;
        @(negedge clk);
        wake_cmd = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 exit timeout err", int'(err), 1);
        chk("R8 exit dropped on err", int'(ulps_exit | esc_req | asleep), 0);
        timeout_limit = CW'(BIG_LIMIT);
        flag_n = 1'b1; stop_state = 1'b1;
        @(negedge clk);

        // Random cycles
        for (int it = 0; it < 25; it++) begin
            int w, d1, d2;
            w  = $urandom_range(0, 14);
            d1 = $urandom_range(0, 4);
            d2 = $urandom_range(0, 4);
            do_sleep(d1, 1'($urandom_range(0, 1)));
            do_wake(d2, w);
        end

        // R9: clock-lane instance
        wake_cycles = '0;
        c_stop = 1'b1; c_flag = 1'b1; c_sleep = 1'b1;
        @(negedge clk);
        c_sleep = 1'b0;
        chk("R9 clock request", int'(c_clk_req), 1);
        chk("R9 escape fields quiet", int'({c_esc_req, c_sel, c_type}), 0);
        c_stop = 1'b0; c_flag = 1'b0;
        @(negedge clk);
        chk("R9 clock lane asleep", int'(c_asleep), 1);
        c_wake = 1'b1;
        @(negedge clk);
        c_wake = 1'b0;
        chk("R9 clock lane exit", int'(c_exit), 1);
        c_flag = 1'b1;
        begin
            int n;
            n = 0;
            forever begin
                @(negedge clk);
                if (!c_clk_req || n > 5000) break;
                n++;
            end
            chk("R9 clock lane hold at floor", n, MIN);
        end
        c_stop = 1'b1;
        @(negedge clk);
        chk("R9 clock lane done", int'(c_done), 1);
        chk("R9 escape request never used", int'(c_esc_req), 0);

        finish_run();
    end
endmodule